// File: doc/BRIEF.md
# Free-Running Tick Timer with Source Select

This block is a memory-mapped timer built around a free-running up-counter. Software reaches it over a small word-addressed register bus. A write takes effect at the clock edge on which it is presented. A read returns its data one cycle later, together with an acknowledge. The counter does not run from a clock of its own. It advances on single-cycle enable pulses that arrive from three places: a peripheral tick, a slow 32 kHz tick and a fast oscillator tick.

A 3-bit code in the control word selects which tick source feeds the counter. The oscillator path has a gate of its own and a 4-bit divider of its own. A 12-bit main divider comes after the source select and applies to every source. A self-clearing software reset returns every register and every divider phase to its default. Software sees this reset as a busy bit for a fixed number of cycles.

Top module: `ftimer_top`

## Requirements
- R1: Register words are addressed by `addr_i`. Offset 0 is control, 1 is prescaler, 2 is status and 9 is the counter. Every other offset reads 0. For each cycle with `req_i` high, `ack_o` is high in the following cycle, and a read's data is on `rdata_o` in that same cycle.
- R2: The control word has these fields: bit 0 enable, bits 8:6 source code, bit 9 mode, bit 10 oscillator gate, bit 15 software reset. Bits 0 and 6 to 10 read back as written. Every other bit reads 0.
- R3: The prescaler word holds the oscillator divisor in bits 15:12 and the main divisor in bits 11:0. Bits 31:16 read 0.
- R4: While control bit 0 is clear, ticks have no effect: the counter and both divider phases hold.
- R5: A source code of 1 selects `per_tick_i`, 4 selects `slow_tick_i` and 5 selects the oscillator path. Any other code produces no counts. With both divisors 0, the counter rises by one at each clock edge where the selected tick is high.
- R6: The oscillator path passes pulses only while control bit 10 is set. It delivers one pulse per (oscillator divisor + 1) oscillator ticks.
- R7: The main divider sits after the oscillator divider. It delivers one count per (main divisor + 1) selected ticks.
- R8: The counter wraps from all ones to zero.
- R9: A write of 1 to control bit 15 clears control, prescaler, counter and both divider phases. Bit 15 then reads 1 for 4 cycles after the write edge and reads 0 afterwards. Register writes made during those cycles are ignored.
- R10: The status word always reads 0. Writes to the status and counter offsets are ignored.
- R11: The asynchronous reset `rst_ni` clears every register and the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access request |
| we_i | input | 1 | Write when 1, read when 0 |
| addr_i | input | 4 | Word offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid with ack_o |
| ack_o | output | 1 | Response, one cycle after req_i |
| per_tick_i | input | 1 | Peripheral tick enable pulse |
| slow_tick_i | input | 1 | 32 kHz tick enable pulse |
| osc_tick_i | input | 1 | Oscillator tick enable pulse |

## Verification
The assertions assume that the tick inputs are synchronous to `clk_i` and only sampled at its edges. They also assume that every bus request lasts a single cycle, so that each read is paired with the acknowledge that follows it. The bench drives all inputs on the falling edge. It raises each tick for a whole number of cycles and only when the bus is idle, and it clears each request after one cycle. Every counter read therefore sees a value that has settled.

// File: rtl/ftimer_pkg.sv
package ftimer_pkg;
  localparam int ADDR_W     = 4;
  localparam logic [ADDR_W-1:0] OFF_CTRL  = 4'd0;
  localparam logic [ADDR_W-1:0] OFF_PRESC = 4'd1;
  localparam logic [ADDR_W-1:0] OFF_STAT  = 4'd2;
  localparam logic [ADDR_W-1:0] OFF_CNT   = 4'd9;

  localparam int B_EN       = 0;
  localparam int B_SRC_LO   = 6;
  localparam int SRC_W      = 3;
  localparam int B_MODE     = 9;
  localparam int B_OSC_EN   = 10;
  localparam int B_SWR      = 15;
  localparam int OSC_DIV_LO = 12;

  localparam logic [SRC_W-1:0] SRC_PER  = 3'd1;
  localparam logic [SRC_W-1:0] SRC_SLOW = 3'd4;
  localparam logic [SRC_W-1:0] SRC_OSC  = 3'd5;

  localparam int SWR_CYC   = 4;
  localparam int SWR_CNT_W = $clog2(SWR_CYC + 1);
endpackage

// File: rtl/ftimer_div.sv
module ftimer_div #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         tick_i,
  input  logic [W-1:0] div_i,
  output logic         pulse_o
);
  logic [W-1:0] ph_q;
  logic         wrap;

  // >= so that lowering the divisor never stalls the phase
  assign wrap    = (ph_q >= div_i);
  assign pulse_o = tick_i & wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ph_q <= '0;
    else if (clr_i)  ph_q <= '0;
    else if (tick_i) ph_q <= wrap ? '0 : ph_q + 1'b1;
  end
endmodule

// File: rtl/ftimer_src_sel.sv
module ftimer_src_sel
  import ftimer_pkg::*;
(
  input  logic [SRC_W-1:0] src_i,
  input  logic             per_i,
  input  logic             slow_i,
  input  logic             osc_i,
  output logic             tick_o
);
  always_comb begin
    case (src_i)
      SRC_PER:  tick_o = per_i;
      SRC_SLOW: tick_o = slow_i;
      SRC_OSC:  tick_o = osc_i;
      default:  tick_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/ftimer_cnt.sv
module ftimer_cnt #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_o <= '0;
    else if (clr_i) cnt_o <= '0;
    else if (inc_i) cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/ftimer_regs.sv
module ftimer_regs
  import ftimer_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int CNT_W      = 32,
  parameter int OSC_DIV_W  = 4,
  parameter int MAIN_DIV_W = 12
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_i,
  input  logic                  we_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [DATA_W-1:0]     wdata_i,
  input  logic [CNT_W-1:0]      count_i,
  output logic [DATA_W-1:0]     rdata_o,
  output logic                  ack_o,
  output logic                  en_o,
  output logic [SRC_W-1:0]      src_o,
  output logic                  osc_en_o,
  output logic [OSC_DIV_W-1:0]  osc_div_o,
  output logic [MAIN_DIV_W-1:0] main_div_o,
  output logic                  busy_o,
  output logic                  clr_o
);
  logic                 mode_q;
  logic [SWR_CNT_W-1:0] swr_cnt_q;
  logic                 wr, swr_go;
  logic [DATA_W-1:0]    rd_mux;
  logic                 unused_wdata;

  assign unused_wdata = ^wdata_i;
  assign busy_o = (swr_cnt_q != '0);
  assign wr     = req_i & we_i & ~busy_o;
  assign swr_go = wr && (addr_i == OFF_CTRL) && wdata_i[B_SWR];
  assign clr_o  = swr_go | busy_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o       <= 1'b0;
      src_o      <= '0;
      mode_q     <= 1'b0;
      osc_en_o   <= 1'b0;
      osc_div_o  <= '0;
      main_div_o <= '0;
      swr_cnt_q  <= '0;
    end else if (swr_go) begin
      en_o       <= 1'b0;
      src_o      <= '0;
      mode_q     <= 1'b0;
      osc_en_o   <= 1'b0;
      osc_div_o  <= '0;
      main_div_o <= '0;
      swr_cnt_q  <= SWR_CNT_W'(SWR_CYC);
    end else begin
      if (busy_o) swr_cnt_q <= swr_cnt_q - 1'b1;
      if (wr && addr_i == OFF_CTRL) begin
        en_o     <= wdata_i[B_EN];
        src_o    <= wdata_i[B_SRC_LO +: SRC_W];
        mode_q   <= wdata_i[B_MODE];
        osc_en_o <= wdata_i[B_OSC_EN];
      end
      if (wr && addr_i == OFF_PRESC) begin
        osc_div_o  <= wdata_i[OSC_DIV_LO +: OSC_DIV_W];
        main_div_o <= wdata_i[MAIN_DIV_W-1:0];
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    case (addr_i)
      OFF_CTRL: begin
        rd_mux[B_EN]              = en_o;
        rd_mux[B_SRC_LO +: SRC_W] = src_o;
        rd_mux[B_MODE]            = mode_q;
        rd_mux[B_OSC_EN]          = osc_en_o;
        rd_mux[B_SWR]             = busy_o;
      end
      OFF_PRESC: begin
        rd_mux[OSC_DIV_LO +: OSC_DIV_W] = osc_div_o;
        rd_mux[MAIN_DIV_W-1:0]          = main_div_o;
      end
      OFF_CNT: rd_mux[CNT_W-1:0] = count_i;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_o   <= 1'b0;
      rdata_o <= '0;
    end else begin
      ack_o <= req_i;
      if (req_i && !we_i) rdata_o <= rd_mux;
    end
  end
endmodule

// File: rtl/ftimer_top.sv
module ftimer_top
  import ftimer_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int CNT_W      = 32,
  parameter int OSC_DIV_W  = 4,
  parameter int MAIN_DIV_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              ack_o,
  input  logic              per_tick_i,
  input  logic              slow_tick_i,
  input  logic              osc_tick_i
);
  logic                  ctrl_en, osc_en, swr_busy, clr;
  logic [SRC_W-1:0]      ctrl_src;
  logic [OSC_DIV_W-1:0]  osc_div;
  logic [MAIN_DIV_W-1:0] main_div;
  logic                  osc_gate, osc_pulse, sel_tick, main_tick, cnt_inc;
  logic [CNT_W-1:0]      count_q;

  ftimer_regs #(
    .DATA_W(DATA_W), .CNT_W(CNT_W), .OSC_DIV_W(OSC_DIV_W), .MAIN_DIV_W(MAIN_DIV_W)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .count_i(count_q), .rdata_o(rdata_o), .ack_o(ack_o),
    .en_o(ctrl_en), .src_o(ctrl_src), .osc_en_o(osc_en), .osc_div_o(osc_div),
    .main_div_o(main_div), .busy_o(swr_busy), .clr_o(clr)
  );

  assign osc_gate = osc_tick_i & osc_en & ctrl_en;

  ftimer_div #(.W(OSC_DIV_W)) u_osc_div (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr), .tick_i(osc_gate),
    .div_i(osc_div), .pulse_o(osc_pulse)
  );

  ftimer_src_sel u_sel (
    .src_i(ctrl_src), .per_i(per_tick_i), .slow_i(slow_tick_i),
    .osc_i(osc_pulse), .tick_o(sel_tick)
  );

  assign main_tick = sel_tick & ctrl_en;

  ftimer_div #(.W(MAIN_DIV_W)) u_main_div (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr), .tick_i(main_tick),
    .div_i(main_div), .pulse_o(cnt_inc)
  );

  ftimer_cnt #(.W(CNT_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr), .inc_i(cnt_inc), .cnt_o(count_q)
  );
endmodule

// File: rtl/ftimer_chk.sv
module ftimer_chk
  import ftimer_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              ack_o,
  input logic [CNT_W-1:0]  count_i,
  input logic              en_i,
  input logic [SRC_W-1:0]  src_i,
  input logic              busy_i
);
  logic swr_wr, bad_src, stat_rd;
  assign swr_wr  = req_i && we_i && (addr_i == OFF_CTRL) && wdata_i[B_SWR];
  assign bad_src = (src_i != SRC_PER) && (src_i != SRC_SLOW) && (src_i != SRC_OSC);
  assign stat_rd = req_i && !we_i && (addr_i == OFF_STAT);

  AST_ACK_AFTER_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> ack_o); // R1
  AST_HOLD_WHEN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !swr_wr) |=> $stable(count_i)); // R4
  AST_NO_COUNT_BAD_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bad_src && !swr_wr) |=> $stable(count_i)); // R5
  AST_STEP_OR_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(count_i) |-> (count_i == $past(count_i) + 1'b1) || (count_i == '0)); // R8
  AST_SWR_LENGTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_i) |-> ($past(busy_i, 4) && !$past(busy_i, 5))); // R9
  AST_STATUS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o && $past(stat_rd)) |-> (rdata_o == '0)); // R10
endmodule

bind ftimer_top ftimer_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
  .wdata_i(wdata_i), .rdata_o(rdata_o), .ack_o(ack_o), .count_i(count_q),
  .en_i(ctrl_en), .src_i(ctrl_src), .busy_i(swr_busy)
);

// File: tb/ftimer_top_tb_top.sv
module ftimer_top_tb_top;
  import ftimer_pkg::*;
  localparam int CNT_W = 10;

  logic clk = 1'b0, rst_n = 1'b0, req = 1'b0, we = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic ack, per = 1'b0, slow = 1'b0, osc = 1'b0;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ftimer_top #(.CNT_W(CNT_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .ack_o(ack), .per_tick_i(per),
    .slow_tick_i(slow), .osc_tick_i(osc)
  );

  typedef struct packed {
    logic [2:0] src; logic oen; logic [3:0] od; logic [11:0] md;
    logic [7:0] pn; logic [7:0] sn; logic [7:0] on;
  } vec_t;

  localparam vec_t VECS[10] = '{
    '{3'd1, 1'b0, 4'd0, 12'd0, 8'd5,  8'd3, 8'd3},
    '{3'd1, 1'b0, 4'd0, 12'd2, 8'd7,  8'd0, 8'd0},
    '{3'd4, 1'b0, 4'd0, 12'd0, 8'd3,  8'd6, 8'd2},
    '{3'd4, 1'b0, 4'd0, 12'd1, 8'd0,  8'd9, 8'd0},
    '{3'd5, 1'b1, 4'd7, 12'd0, 8'd4,  8'd0, 8'd24},
    '{3'd5, 1'b0, 4'd0, 12'd0, 8'd0,  8'd0, 8'd5},
    '{3'd5, 1'b1, 4'd1, 12'd1, 8'd0,  8'd0, 8'd12},
    '{3'd2, 1'b1, 4'd0, 12'd0, 8'd5,  8'd5, 8'd5},
    '{3'd7, 1'b1, 4'd0, 12'd0, 8'd5,  8'd5, 8'd5},
    '{3'd0, 1'b1, 4'd0, 12'd0, 8'd5,  8'd5, 8'd5}
  };

  function automatic int exp_count(vec_t v);
    int t;
    case (v.src)
      3'd1:    t = int'(v.pn);
      3'd4:    t = int'(v.sn);
      3'd5:    t = v.oen ? int'(v.on) / (int'(v.od) + 1) : 0;
      default: t = 0;
    endcase
    return t / (int'(v.md) + 1);
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    req = 1'b0;
    d = rdata;
  endtask

  task automatic tick(input int sel, input int n);
    if (n == 0) return;
    if (sel == 0) per = 1'b1; else if (sel == 1) slow = 1'b1; else osc = 1'b1;
    repeat (n) @(negedge clk);
    per = 1'b0; slow = 1'b0; osc = 1'b0;
  endtask

  task automatic sreset();
    wr(OFF_CTRL, 32'h8000);
    repeat (SWR_CYC + 1) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    rd(OFF_CTRL, d);  chk("R11 ctrl", d, 32'h0);
    rd(OFF_PRESC, d); chk("R11 presc", d, 32'h0);
    rd(OFF_CNT, d);   chk("R11 count", d, 32'h0);
    // R1 response timing and unused offset
    rd(OFF_STAT, d);  chk("R1 ack high", {31'b0, ack}, 32'h1);
    @(negedge clk);   chk("R1 ack low", {31'b0, ack}, 32'h0);
    rd(4'd5, d);      chk("R1 unused offset", d, 32'h0);
    // R2 / R3 field layout
    wr(OFF_CTRL, 32'hFFFF_7FFF);  rd(OFF_CTRL, d);  chk("R2 ctrl readback", d, 32'h0000_07C1);
    wr(OFF_PRESC, 32'hFFFF_FFFF); rd(OFF_PRESC, d); chk("R3 presc readback", d, 32'h0000_FFFF);

    // R5 R6 R7 vector walk
    foreach (VECS[i]) begin
      vec_t v = VECS[i];
      string tag;
      tag = (v.src == 3'd5) ? "R6" : (v.md != 0) ? "R7" : "R5";
      sreset();
      wr(OFF_PRESC, {16'b0, v.od, v.md});
      wr(OFF_CTRL, {21'b0, v.oen, 1'b0, v.src, 5'b0, 1'b1});
      tick(0, int'(v.pn));
      tick(1, int'(v.sn));
      tick(2, int'(v.on));
      rd(OFF_CNT, d);
      chk($sformatf("%s vec%0d", tag, i), d, 32'(exp_count(v)));
    end

    // R4 enable gating
    sreset();
    wr(OFF_CTRL, 32'h40); tick(0, 5); rd(OFF_CNT, d); chk("R4 disabled", d, 32'd0);
    wr(OFF_CTRL, 32'h41); tick(0, 3); rd(OFF_CNT, d); chk("R4 enabled", d, 32'd3);
    wr(OFF_CTRL, 32'h40); tick(0, 4); rd(OFF_CNT, d); chk("R4 hold", d, 32'd3);
    // R10 ignored writes
    wr(OFF_CNT, 32'h55); wr(OFF_STAT, 32'hFF);
    rd(OFF_CNT, d);  chk("R10 count write ignored", d, 32'd3);
    rd(OFF_STAT, d); chk("R10 status zero", d, 32'd0);

    // R8 wrap
    sreset();
    wr(OFF_CTRL, 32'h41);
    tick(0, 1023); rd(OFF_CNT, d); chk("R8 all ones", d, 32'h3FF);
    tick(0, 1);    rd(OFF_CNT, d); chk("R8 wrap zero", d, 32'h0);
    tick(0, 1);    rd(OFF_CNT, d); chk("R8 after wrap", d, 32'h1);

    // R9 software reset
    wr(OFF_PRESC, 32'h2); tick(0, 2);
    wr(OFF_CTRL, 32'h8000);
    rd(OFF_CTRL, d);      chk("R9 busy first", d, 32'h8000);
    wr(OFF_PRESC, 32'h5);
    rd(OFF_CTRL, d);      chk("R9 busy last", d, 32'h8000);
    @(negedge clk);
    rd(OFF_CTRL, d);      chk("R9 busy cleared", d, 32'h0);
    rd(OFF_PRESC, d);     chk("R9 presc cleared", d, 32'h0);
    rd(OFF_CNT, d);       chk("R9 count cleared", d, 32'h0);
    wr(OFF_PRESC, 32'h2); wr(OFF_CTRL, 32'h41);
    tick(0, 2); rd(OFF_CNT, d); chk("R9 phase cleared", d, 32'h0);
    tick(0, 1); rd(OFF_CNT, d); chk("R9 phase count", d, 32'h1);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule